// File: doc/BRIEF.md
# External Interrupt Request Controller

This block collects six active-low maskable request pins and one active-low non-maskable pin. It turns them into a single interrupt request toward the CPU, together with a vector number. Every pin is synchronised to the system clock. The first capture happens on the falling clock edge, and a second stage follows on the rising edge.

Software programs two 6-bit registers through a small write/read port. One register holds a per-line enable. The other holds a per-line sense select, which chooses low-level or falling-edge detection. The CPU supplies a global mask bit that blocks every maskable line. The non-maskable line ignores that mask and the enables. It is detected on its falling edge only.

When several requests are pending, a fixed priority picks one. The CPU pulses an acknowledge while a request is shown. That acknowledge clears the edge latch of the line that was presented.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, `req_o` is 0 and `vec_o` is 0. `vec_o` is 0 whenever `req_o` is 0.
- R2: A write with `reg_sel_i`=0 loads the enable register, and a write with `reg_sel_i`=1 loads the sense register. Only data bits 5..0 are stored, with bit i belonging to line i. `reg_rdata_o` shows the selected register, with bits 7..6 reading 0.
- R3: With sense bit i = 0 (level mode), line i requests for as long as its pin is low and stops once the pin returns high.
- R4: With sense bit i = 1 (edge mode), a high-to-low transition latches a request for line i. An acknowledge of that line clears it, and a pin held low afterwards raises no new request.
- R5: A maskable line whose enable bit is 0 never produces `req_o`.
- R6: While `mask_i` is 1, no maskable line produces `req_o`. Once `mask_i` returns to 0, pending lines are presented again.
- R7: A falling edge on `nmi_n_i` raises a request with vector 7, whatever the mask and the enables. It stays until acknowledged, and holding the pin low does not raise it again.
- R8: Priority is fixed: the non-maskable line first, then line 0 up to line 5. The vector is 7 for the non-maskable line and 12+i for line i.
- R9: An acknowledge while `req_o` is 0 clears nothing. An acknowledge of a level-mode line leaves the request standing while its pin stays low.
- R10: An edge-mode latch stays set after its pin returns high, until it is acknowledged.
- R11: An edge latched while its line is disabled or masked is presented once the line becomes enabled and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n_i | input | 6 | Maskable request pins, active low, bit i = line i |
| nmi_n_i | input | 1 | Non-maskable request pin, active low |
| mask_i | input | 1 | Global mask from CPU status; 1 blocks maskable lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 enable, 1 sense |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register contents |
| req_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 8 | Vector number of the presented request |
| ack_i | input | 1 | Acknowledge of the presented request |

## Verification
The assertions take three things for granted. The CPU pulses `ack_i` for a single cycle. A write strobe lasts one cycle with stable select and data. Pins change no faster than the synchroniser can follow. The bench meets these by changing pins and control only a little after a rising edge and holding each change for several cycles. It drives acknowledge and write strobes as one-cycle pulses. It samples outputs on the falling edge, after enough cycles for the two synchroniser stages and the edge latch to settle.

// File: rtl/xirq_pkg.sv
// Package: shared constants for the external interrupt request controller.
// Assumes: vectors fit in eight bits.
package xirq_pkg;
    localparam int unsigned NUM_IRQ      = 6;
    localparam int unsigned DATA_W       = 8;
    localparam int unsigned VEC_W        = 8;
    localparam int unsigned VEC_NMI      = 7;
    localparam int unsigned VEC_IRQ_BASE = 12;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_SENSE  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/xirq_sync.sv
// Module: two-stage pin synchroniser.
// Stage one samples the raw pins on the falling clock edge; stage two
// retimes them to the rising edge. Output is active-high request.
// Assumes: pins are idle high (active-low requests).
module xirq_sync #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n_i,
    output logic [W-1:0] req_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Capture raw pins at the falling clock edge.
    always_ff @(negedge clk) begin
        if (!rst_n) stage1_q <= '1;
        else        stage1_q <= pin_n_i;
    end

    // Retime to the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stage2_q <= '1;
        else        stage2_q <= stage1_q;
    end

    assign req_o = ~stage2_q;
endmodule

// File: rtl/xirq_detect.sv
// Module: per-line level / falling-edge detection with edge latches.
// In edge mode a latch is set on a new request and cleared by clr_i;
// a new edge wins over a clear in the same cycle. In level mode the
// synchronised request passes straight through and the latch is held clear.
// Assumes: req_i is already synchronised.
module xirq_detect #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] edge_mode_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] latch_q;

    // Remember last request level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= req_i;
    end

    for (genvar g = 0; g < N; g++) begin : g_line
        logic fall;
        assign fall = req_i[g] & ~prev_q[g];

        // Hold an edge request until acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)               latch_q[g] <= 1'b0;
            else if (!edge_mode_i[g]) latch_q[g] <= 1'b0;
            else if (fall)            latch_q[g] <= 1'b1;
            else if (clr_i[g])        latch_q[g] <= 1'b0;
        end

        assign pend_o[g] = edge_mode_i[g] ? latch_q[g] : req_i[g];
    end
endmodule

// File: rtl/xirq_regs.sv
// Module: enable and sense registers with a write/read port.
// Assumes: one write per strobe cycle; unused data bits are dropped.
module xirq_regs #(
    parameter int unsigned N      = 6,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      sense_o
);
    import xirq_pkg::*;

    logic [N-1:0] en_q;
    logic [N-1:0] sense_q;

    // Register writes, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            sense_q <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_ENABLE) en_q    <= wdata_i[N-1:0];
            else                     sense_q <= wdata_i[N-1:0];
        end
    end

    // Read mux, upper bits zero.
    always_comb begin
        rdata_o        = '0;
        rdata_o[N-1:0] = (sel_i == SEL_SENSE) ? sense_q : en_q;
    end

    assign en_o    = en_q;
    assign sense_o = sense_q;
endmodule

// File: rtl/xirq_arbiter.sv
// Module: masking and fixed-priority selection with vector encoding.
// Priority: non-maskable first, then line 0 to line N-1.
// grant_o bit 0 is the non-maskable line, bit i+1 is line i.
module xirq_arbiter #(
    parameter int unsigned N        = 6,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned VEC_NMI  = 7,
    parameter int unsigned VEC_BASE = 12
) (
    input  logic             nmi_pend_i,
    input  logic [N-1:0]     irq_pend_i,
    input  logic [N-1:0]     en_i,
    input  logic             mask_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N:0]       grant_o
);
    logic [N-1:0] cand;

    assign cand = irq_pend_i & en_i & {N{~mask_i}};

    // Pick the winner; lower index overrides higher, NMI overrides all.
    always_comb begin
        req_o   = 1'b0;
        vec_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                req_o        = 1'b1;
                vec_o        = VEC_W'(VEC_BASE + i);
                grant_o      = '0;
                grant_o[i+1] = 1'b1;
            end
        end
        if (nmi_pend_i) begin
            req_o      = 1'b1;
            vec_o      = VEC_W'(VEC_NMI);
            grant_o    = '0;
            grant_o[0] = 1'b1;
        end
    end
endmodule

// File: rtl/xirq_ctrl.sv
// Module: external interrupt request controller top.
// Synchronises pins, detects level/edge requests, applies enables and the
// global mask, and presents one request with a vector to the CPU.
// Assumes: ack_i is a one-cycle pulse aimed at the presented request.
module xirq_ctrl #(
    parameter int unsigned NUM_IRQ      = xirq_pkg::NUM_IRQ,
    parameter int unsigned DATA_W       = xirq_pkg::DATA_W,
    parameter int unsigned VEC_W        = xirq_pkg::VEC_W,
    parameter int unsigned VEC_NMI      = xirq_pkg::VEC_NMI,
    parameter int unsigned VEC_IRQ_BASE = xirq_pkg::VEC_IRQ_BASE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_n_i,
    input  logic               nmi_n_i,
    input  logic               mask_i,
    input  logic               reg_wr_i,
    input  logic               reg_sel_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               req_o,
    output logic [VEC_W-1:0]   vec_o,
    input  logic               ack_i
);
    localparam int unsigned PINS = NUM_IRQ + 1;

    logic [PINS-1:0]    pin_req;
    logic [NUM_IRQ-1:0] en_q;
    logic [NUM_IRQ-1:0] sense_q;
    logic [NUM_IRQ-1:0] irq_pend;
    logic               nmi_pend;
    logic [NUM_IRQ:0]   grant;
    logic [NUM_IRQ:0]   clr;

    xirq_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i ({irq_n_i, nmi_n_i}),
        .req_o   (pin_req)
    );

    xirq_regs #(.N(NUM_IRQ), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .sel_i   (reg_sel_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .en_o    (en_q),
        .sense_o (sense_q)
    );

    // Acknowledge clears only the line currently granted.
    assign clr = grant & {(NUM_IRQ + 1){ack_i & req_o}};

    xirq_detect #(.N(NUM_IRQ)) u_det_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (pin_req[PINS-1:1]),
        .edge_mode_i (sense_q),
        .clr_i       (clr[NUM_IRQ:1]),
        .pend_o      (irq_pend)
    );

    xirq_detect #(.N(1)) u_det_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (pin_req[0]),
        .edge_mode_i (1'b1),
        .clr_i       (clr[0]),
        .pend_o      (nmi_pend)
    );

    xirq_arbiter #(
        .N(NUM_IRQ), .VEC_W(VEC_W), .VEC_NMI(VEC_NMI), .VEC_BASE(VEC_IRQ_BASE)
    ) u_arb (
        .nmi_pend_i (nmi_pend),
        .irq_pend_i (irq_pend),
        .en_i       (en_q),
        .mask_i     (mask_i),
        .req_o      (req_o),
        .vec_o      (vec_o),
        .grant_o    (grant)
    );
endmodule

// File: rtl/xirq_checker.sv
// Module: property checker for xirq_ctrl, attached by bind.
// Assumes: single-cycle ack and write strobes.
module xirq_checker #(
    parameter int unsigned NUM_IRQ      = 6,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned VEC_W        = 8,
    parameter int unsigned VEC_NMI      = 7,
    parameter int unsigned VEC_IRQ_BASE = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_i,
    input logic               ack_i,
    input logic               req_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic               reg_wr_i,
    input logic               reg_sel_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic [NUM_IRQ-1:0] en_q
);
    logic [NUM_IRQ-1:0] vec_hit;
    logic               vec_is_nmi;

    // Decode the vector back to a line index, one-hot.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++)
            vec_hit[i] = (vec_o == VEC_W'(VEC_IRQ_BASE + i));
    end
    assign vec_is_nmi = (vec_o == VEC_W'(VEC_NMI));

    // R1: no request, no vector.
    p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_o |-> vec_o == '0);

    // R8: vector is always one of the legal codes.
    p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (vec_is_nmi || $onehot(vec_hit)));

    // R5: a maskable vector belongs to an enabled line.
    p_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !vec_is_nmi) |-> |(vec_hit & en_q));

    // R6: while masked only the non-maskable vector appears.
    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && mask_i) |-> vec_is_nmi);

    // R7: a presented non-maskable request holds until acknowledged.
    p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && vec_is_nmi && !ack_i) |=> (req_o && vec_is_nmi));

    // R2: an enable write lands in the enable register.
    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && !reg_sel_i) |=> en_q == $past(reg_wdata_i[NUM_IRQ-1:0]));
endmodule

bind xirq_ctrl xirq_checker #(
    .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .VEC_NMI(VEC_NMI), .VEC_IRQ_BASE(VEC_IRQ_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_i      (mask_i),
    .ack_i       (ack_i),
    .req_o       (req_o),
    .vec_o       (vec_o),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .en_q        (en_q)
);

// File: tb/xirq_ctrl_bench.sv
`timescale 1ns/1ps
// Directed bench for xirq_ctrl: one task per scenario.
module xirq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] irq_n = '1;
    logic       nmi_n = 1'b1;
    logic       mask = 1'b0;
    logic       wr = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       req;
    logic [7:0] vec;
    logic       ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    xirq_ctrl u_xirq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .nmi_n_i(nmi_n),
        .mask_i(mask), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .req_o(req), .vec_o(vec), .ack_i(ack)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] d);
        step(); wr = 1'b1; sel = s; wdata = d;
        step(); wr = 1'b0;
    endtask

    task automatic pulse_ack();
        step(); ack = 1'b1;
        step(); ack = 1'b0;
    endtask

    task automatic set_pin(input int i, input logic v);
        step(); irq_n[i] = v;
    endtask

    task automatic restore();
        step(); irq_n = '1; nmi_n = 1'b1; mask = 1'b0;
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
        settle(4);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 req", req, 0);
        chk("R1 vec", vec, 0);
        sel = 1'b0; #1 chk("R1 enable", rdata, 8'h00);
        sel = 1'b1; #1 chk("R1 sense", rdata, 8'h00);
    endtask

    task automatic t_regs();
        wr_reg(1'b0, 8'hFF);
        wr_reg(1'b1, 8'hA5);
        @(negedge clk);
        sel = 1'b0; #1 chk("R2 enable read", rdata, 8'h3F);
        sel = 1'b1; #1 chk("R2 sense read", rdata, 8'h25);
        restore();
    endtask

    task automatic t_level();
        wr_reg(1'b0, 8'h04);
        set_pin(2, 1'b0); settle(3);
        chk("R3 level req", req, 1);
        chk("R3 level vec", vec, 14);
        pulse_ack(); settle(2);
        chk("R9 level ack keeps req", req, 1);
        set_pin(2, 1'b1); settle(3);
        chk("R3 level released", req, 0);
        restore();
    endtask

    task automatic t_edge();
        wr_reg(1'b1, 8'h02);
        wr_reg(1'b0, 8'h02);
        set_pin(1, 1'b0); settle(4);
        chk("R4 edge req", req, 1);
        chk("R4 edge vec", vec, 13);
        pulse_ack(); settle(4);
        chk("R4 held low no repeat", req, 0);
        set_pin(1, 1'b1); settle(3);
        set_pin(1, 1'b0); settle(3);
        set_pin(1, 1'b1); settle(4);
        chk("R10 latch after release", req, 1);
        chk("R10 latch vec", vec, 13);
        pulse_ack(); settle(2);
        chk("R4 ack clears", req, 0);
        restore();
    endtask

    task automatic t_disabled();
        set_pin(3, 1'b0); settle(4);
        chk("R5 disabled line", req, 0);
        wr_reg(1'b0, 8'h08); settle(1);
        chk("R5 enabled line vec", vec, 15);
        restore();
    endtask

    task automatic t_mask();
        wr_reg(1'b0, 8'h01);
        step(); mask = 1'b1;
        set_pin(0, 1'b0); settle(4);
        chk("R6 masked", req, 0);
        step(); mask = 1'b0; settle(1);
        chk("R6 unmasked vec", vec, 12);
        step(); mask = 1'b1; settle(1);
        chk("R6 remasked", req, 0);
        restore();
    endtask

    task automatic t_nmi();
        step(); mask = 1'b1;
        step(); nmi_n = 1'b0; settle(4);
        chk("R7 nmi req", req, 1);
        chk("R7 nmi vec", vec, 7);
        pulse_ack(); settle(4);
        chk("R7 held low no repeat", req, 0);
        restore();
    endtask

    task automatic t_priority();
        wr_reg(1'b0, 8'h3F);
        step(); irq_n = '0; settle(3);
        chk("R8 line0 first", vec, 12);
        step(); nmi_n = 1'b0; settle(4);
        chk("R8 nmi over all", vec, 7);
        pulse_ack(); settle(1);
        chk("R8 after nmi ack", vec, 12);
        for (int i = 0; i < 5; i++) begin
            set_pin(i, 1'b1); settle(3);
            chk("R8 next line", vec, 32'(13 + i));
        end
        restore();
    endtask

    task automatic t_late_enable();
        wr_reg(1'b1, 8'h30);
        set_pin(4, 1'b0); settle(3);
        set_pin(4, 1'b1);
        set_pin(5, 1'b0); settle(3);
        set_pin(5, 1'b1); settle(3);
        chk("R11 latched while disabled", req, 0);
        pulse_ack(); settle(1);
        wr_reg(1'b0, 8'h20); settle(1);
        chk("R9 idle ack ignored, R11 vec", vec, 17);
        step(); mask = 1'b1;
        wr_reg(1'b0, 8'h30); settle(1);
        chk("R11 masked", req, 0);
        step(); mask = 1'b0; settle(1);
        chk("R11 unmasked vec", vec, 16);
        restore();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_disabled();
        t_mask();
        t_nmi();
        t_priority();
        t_late_enable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule